// File: doc/BRIEF.md
# Receive Mailbox Bank with Overwrite Protection

This block sits behind a frame deserializer on a CAN node and keeps the received frames in a bank of receive mailboxes that together act as a FIFO. Each completed frame carries an extended-format flag, a 29-bit identifier field, a length code, a remote-request flag and eight data bytes. The frame is held for one cycle and then committed to the highest-numbered receive mailbox that may take it. A mailbox may take a frame when it is empty, or when its overwrite protection is off. Mailbox indices below `NUM_TX` belong to transmit and never receive.

Every committed frame sets that mailbox's pending flag. The mailbox also latches the local network time counter, which is free running. If a frame lands on a mailbox that is already pending, which can only happen when that mailbox is unprotected, the mailbox's lost flag is raised. The usual setup protects every receive mailbox except the lowest one. Frames then fill the bank from the top, and only the bottom mailbox can be overwritten.

A host reads the pending and lost vectors and selects a mailbox to read its identifier, length, flags, data and timestamp. It clears pending flags by writing 1s, and those writes also clear the matching lost flags. An interrupt request is raised while any pending mailbox has its mask bit set.

The controller is a two-state machine:
- `S_IDLE`: no frame is held. On `frm_valid` the frame is captured and the next state is `S_COMMIT`.
- `S_COMMIT`: the held frame is written to the chosen mailbox at the next edge. If `frm_valid` is asserted in the same cycle, the new frame is captured and the state stays `S_COMMIT`. Otherwise the next state is `S_IDLE`.

Top module: `rxmb_bank`

## Requirements
- R1: After reset, all pending bits and all lost bits are 0. `rx_irq` is 0 and `lnt_o` is 0.
- R2: Only indices `NUM_TX` to `NUM_MBOX-1` are receive mailboxes. Pending and lost bits below `NUM_TX` are always 0.
- R3: A frame sampled with `frm_valid` at one rising edge is committed at the next rising edge. It goes to the highest-index receive mailbox that is either not pending or has its `prot_en` bit at 0, and that mailbox's pending bit is set.
- R4: Committing to a mailbox whose pending bit is already 1 sets that mailbox's lost bit. The pending bit stays 1 and the contents are replaced.
- R5: If every receive mailbox is pending and protected, the frame is discarded. Pending bits, lost bits and mailbox contents do not change.
- R6: A cycle with `clr_we`=1 clears the pending and lost bits of every mailbox whose `clr_mask` bit is 1. Other bits are left as they were.
- R7: `lnt_o` increments by 1 every clock and wraps at `TS_W` bits. A committed mailbox's timestamp equals the `lnt_o` value of the cycle just before the commit edge.
- R8: The stored identifier word puts the extended flag in bit 31 and leaves bits 30:29 at 0. An extended frame stores `frm_ident` in bits 28:0. A standard frame stores `frm_ident[28:18]` in bits 28:18 and stores 0 in bits 17:0.
- R9: The length code, remote flag and 64-bit data of a committed frame are returned unchanged for the mailbox chosen by `rd_sel`.
- R10: `rx_irq` is 1 exactly while some bit of `pending_o & irq_mask` is 1.
- R11: Frames on consecutive cycles are all stored. The earlier frame goes to the higher-index mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | A completed frame is present this cycle |
| frm_ext | input | 1 | Extended-format identifier |
| frm_ident | input | 29 | Identifier field (standard identifier in 28:18) |
| frm_dlc | input | 4 | Length code |
| frm_rtr | input | 1 | Remote request flag |
| frm_data | input | 64 | Data bytes |
| prot_en | input | NUM_MBOX | Per-mailbox overwrite protection |
| clr_we | input | 1 | Write strobe for clearing pending flags |
| clr_mask | input | NUM_MBOX | Write-1-to-clear mask |
| irq_mask | input | NUM_MBOX | Interrupt mask per mailbox |
| rd_sel | input | $clog2(NUM_MBOX) | Mailbox selected for readback |
| pending_o | output | NUM_MBOX | Receive-pending flags |
| lost_o | output | NUM_MBOX | Message-lost flags |
| rd_id | output | 32 | Stored identifier word of the selected mailbox |
| rd_dlc | output | 4 | Stored length code |
| rd_rtr | output | 1 | Stored remote flag |
| rd_data | output | 64 | Stored data |
| rd_stamp | output | TS_W | Stored timestamp |
| lnt_o | output | TS_W | Local network time counter |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench builds the bank with `NUM_MBOX`=8 and `NUM_TX`=4, which gives four receive mailboxes, indices 7 down to 4. With only four mailboxes, a handful of frames is enough to fill the bank. The tests then reach the overwrite of the unprotected bottom mailbox, the discard case with every mailbox protected, and the overwrite of an unprotected top mailbox. The default `TS_W` of 16 lets the timestamps be compared directly against the counter values observed in the bench.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;

    typedef enum logic [0:0] {
        S_IDLE   = 1'b0,
        S_COMMIT = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic [31:0] id;
        logic [3:0]  dlc;
        logic        rtr;
        logic [63:0] data;
    } rx_frame_t;

    function automatic logic [31:0] pack_ident(input logic ext, input logic [28:0] ident);
        if (ext) begin
            return {1'b1, 2'b00, ident};
        end
        return {3'b000, ident[28:18], 18'd0};
    endfunction

endpackage

// File: rtl/rxmb_timer.sv
module rxmb_timer #(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] lnt
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lnt <= '0;
        end else begin
            lnt <= lnt + 1'b1;
        end
    end

endmodule

// File: rtl/rxmb_select.sv
module rxmb_select #(
    parameter int NUM_MBOX = 32,
    parameter int NUM_TX   = 4,
    localparam int IW      = $clog2(NUM_MBOX)
) (
    input  logic [NUM_MBOX-1:0] pending,
    input  logic [NUM_MBOX-1:0] prot,
    output logic                hit,
    output logic [IW-1:0]       idx
);

    localparam logic [NUM_MBOX-1:0] RX_BITS = {NUM_MBOX{1'b1}} << NUM_TX;

    logic [NUM_MBOX-1:0] cand;

    for (genvar g = 0; g < NUM_MBOX; g++) begin : g_cand
        assign cand[g] = RX_BITS[g] & (~pending[g] | ~prot[g]);
    end

    // Ascending scan: the last match, i.e. the highest index, wins.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < NUM_MBOX; i++) begin
            if (cand[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/rxmb_slot.sv
module rxmb_slot
    import rxmb_pkg::*;
#(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  rx_frame_t       frame_in,
    input  logic [TS_W-1:0] stamp_in,
    output rx_frame_t       frame_q,
    output logic [TS_W-1:0] stamp_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            stamp_q <= '0;
        end else if (we) begin
            frame_q <= frame_in;
            stamp_q <= stamp_in;
        end
    end

endmodule

// File: rtl/rxmb_bank.sv
module rxmb_bank
    import rxmb_pkg::*;
#(
    parameter int NUM_MBOX = 32,
    parameter int NUM_TX   = 4,
    parameter int TS_W     = 16,
    localparam int IW      = $clog2(NUM_MBOX)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frm_valid,
    input  logic                frm_ext,
    input  logic [28:0]         frm_ident,
    input  logic [3:0]          frm_dlc,
    input  logic                frm_rtr,
    input  logic [63:0]         frm_data,
    input  logic [NUM_MBOX-1:0] prot_en,
    input  logic                clr_we,
    input  logic [NUM_MBOX-1:0] clr_mask,
    input  logic [NUM_MBOX-1:0] irq_mask,
    input  logic [IW-1:0]       rd_sel,
    output logic [NUM_MBOX-1:0] pending_o,
    output logic [NUM_MBOX-1:0] lost_o,
    output logic [31:0]         rd_id,
    output logic [3:0]          rd_dlc,
    output logic                rd_rtr,
    output logic [63:0]         rd_data,
    output logic [TS_W-1:0]     rd_stamp,
    output logic [TS_W-1:0]     lnt_o,
    output logic                rx_irq
);

    localparam logic [NUM_MBOX-1:0] RX_BITS = {NUM_MBOX{1'b1}} << NUM_TX;

    rx_state_e           state_q, state_d;
    rx_frame_t           hold_q;
    logic [NUM_MBOX-1:0] pending_q, pending_d;
    logic [NUM_MBOX-1:0] lost_q, lost_d;
    logic                sel_hit;
    logic [IW-1:0]       sel_idx;
    logic                commit_go;
    logic [TS_W-1:0]     lnt;
    rx_frame_t           slot_frame [NUM_MBOX];
    logic [TS_W-1:0]     slot_stamp [NUM_MBOX];

    rxmb_timer #(.TS_W(TS_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .lnt   (lnt)
    );

    rxmb_select #(.NUM_MBOX(NUM_MBOX), .NUM_TX(NUM_TX)) u_select (
        .pending (pending_q),
        .prot    (prot_en),
        .hit     (sel_hit),
        .idx     (sel_idx)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (frm_valid) state_d = S_COMMIT;
            S_COMMIT: state_d = frm_valid ? S_COMMIT : S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        commit_go = 1'b0;
        unique case (state_q)
            S_IDLE:   commit_go = 1'b0;
            S_COMMIT: commit_go = sel_hit;
            default:  commit_go = 1'b0;
        endcase
    end

    // Frame holding register, loaded whenever a frame arrives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (frm_valid) begin
            hold_q.id   <= pack_ident(frm_ext, frm_ident);
            hold_q.dlc  <= frm_dlc;
            hold_q.rtr  <= frm_rtr;
            hold_q.data <= frm_data;
        end
    end

    // Flag update: host clear first, then the commit sets its target
    always_comb begin
        pending_d = pending_q;
        lost_d    = lost_q;
        if (clr_we) begin
            pending_d = pending_d & ~clr_mask;
            lost_d    = lost_d & ~clr_mask;
        end
        if (commit_go) begin
            pending_d[sel_idx] = 1'b1;
            if (pending_q[sel_idx] && !(clr_we && clr_mask[sel_idx])) begin
                lost_d[sel_idx] = 1'b1;
            end
        end
        pending_d = pending_d & RX_BITS;
        lost_d    = lost_d & RX_BITS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= '0;
            lost_q    <= '0;
        end else begin
            pending_q <= pending_d;
            lost_q    <= lost_d;
        end
    end

    // Storage: receive slots at the upper indices, tied off below
    for (genvar g = 0; g < NUM_MBOX; g++) begin : g_mbox
        if (g >= NUM_TX) begin : g_rx
            rxmb_slot #(.TS_W(TS_W)) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .we       (commit_go && (sel_idx == IW'(g))),
                .frame_in (hold_q),
                .stamp_in (lnt),
                .frame_q  (slot_frame[g]),
                .stamp_q  (slot_stamp[g])
            );
        end else begin : g_tx
            assign slot_frame[g] = '0;
            assign slot_stamp[g] = '0;
        end
    end

    // Host-visible outputs
    assign pending_o = pending_q;
    assign lost_o    = lost_q;
    assign lnt_o     = lnt;
    assign rx_irq    = |(pending_q & irq_mask);
    assign rd_id     = slot_frame[rd_sel].id;
    assign rd_dlc    = slot_frame[rd_sel].dlc;
    assign rd_rtr    = slot_frame[rd_sel].rtr;
    assign rd_data   = slot_frame[rd_sel].data;
    assign rd_stamp  = slot_stamp[rd_sel];

endmodule

// File: rtl/rxmb_checker.sv
module rxmb_checker #(
    parameter int NUM_MBOX = 32,
    parameter int NUM_TX   = 4,
    parameter int TS_W     = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_MBOX-1:0] pending,
    input logic [NUM_MBOX-1:0] lost,
    input logic [TS_W-1:0]     lnt,
    input logic                clr_we,
    input logic [NUM_MBOX-1:0] clr_mask,
    input logic                commit
);

    localparam logic [NUM_MBOX-1:0] TX_BITS = ~({NUM_MBOX{1'b1}} << NUM_TX);

    assert_tx_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pending | lost) & TX_BITS) == '0);

    assert_lost_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lost & ~pending) == '0);

    assert_lnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> lnt == $past(lnt) + 1'b1);

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !clr_we) |=> ($stable(pending) && $stable(lost)));

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !commit) |=> (pending & $past(clr_mask)) == '0);

    assert_single_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> $countones(pending & ~$past(pending)) <= 1);

endmodule

bind rxmb_bank rxmb_checker #(
    .NUM_MBOX (NUM_MBOX),
    .NUM_TX   (NUM_TX),
    .TS_W     (TS_W)
) u_rxmb_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .pending  (pending_q),
    .lost     (lost_q),
    .lnt      (lnt_o),
    .clr_we   (clr_we),
    .clr_mask (clr_mask),
    .commit   (commit_go)
);

// File: tb/rxmb_bank_test.sv
module rxmb_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int NMB = 8;
    localparam int NTX = 4;
    localparam int TSW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            frm_valid = 1'b0;
    logic            frm_ext = 1'b0;
    logic [28:0]     frm_ident = '0;
    logic [3:0]      frm_dlc = '0;
    logic            frm_rtr = 1'b0;
    logic [63:0]     frm_data = '0;
    logic [NMB-1:0]  prot_en = 8'hE0;
    logic            clr_we = 1'b0;
    logic [NMB-1:0]  clr_mask = '0;
    logic [NMB-1:0]  irq_mask = '0;
    logic [2:0]      rd_sel = '0;
    logic [NMB-1:0]  pending_o, lost_o;
    logic [31:0]     rd_id;
    logic [3:0]      rd_dlc;
    logic            rd_rtr;
    logic [63:0]     rd_data;
    logic [TSW-1:0]  rd_stamp, lnt_o;
    logic            rx_irq;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxmb_bank #(.NUM_MBOX(NMB), .NUM_TX(NTX), .TS_W(TSW)) uut (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ext(frm_ext),
        .frm_ident(frm_ident), .frm_dlc(frm_dlc), .frm_rtr(frm_rtr),
        .frm_data(frm_data), .prot_en(prot_en), .clr_we(clr_we),
        .clr_mask(clr_mask), .irq_mask(irq_mask), .rd_sel(rd_sel),
        .pending_o(pending_o), .lost_o(lost_o), .rd_id(rd_id), .rd_dlc(rd_dlc),
        .rd_rtr(rd_rtr), .rd_data(rd_data), .rd_stamp(rd_stamp),
        .lnt_o(lnt_o), .rx_irq(rx_irq)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] std_word(input logic [10:0] sid);
        return {3'b000, sid, 18'd0};
    endfunction

    // Drives one frame; returns the counter value seen just before the commit edge.
    task automatic send(input logic ext, input logic [28:0] ident, input logic [3:0] dlc,
                        input logic rtr, input logic [63:0] data, output logic [TSW-1:0] stamp);
        @(negedge clk);
        frm_valid = 1'b1; frm_ext = ext; frm_ident = ident;
        frm_dlc = dlc; frm_rtr = rtr; frm_data = data;
        @(negedge clk);
        frm_valid = 1'b0;
        stamp = lnt_o;
        @(negedge clk);
    endtask

    task automatic send_std(input logic [10:0] sid, input logic [63:0] data);
        logic [TSW-1:0] s;
        send(1'b0, {sid, 18'h2A5A5}, 4'd8, 1'b0, data, s);
    endtask

    task automatic look(input int idx);
        rd_sel = 3'(idx);
        #1;
    endtask

    task automatic clear(input logic [NMB-1:0] m);
        @(negedge clk);
        clr_we = 1'b1; clr_mask = m;
        @(negedge clk);
        clr_we = 1'b0; clr_mask = '0;
    endtask

    task automatic t_reset();
        logic [TSW-1:0] a;
        check("R1 pending after reset", 64'(pending_o), 64'h0);
        check("R1 lost after reset", 64'(lost_o), 64'h0);
        check("R1 irq after reset", 64'(rx_irq), 64'h0);
        a = lnt_o;
        repeat (5) @(negedge clk);
        check("R7 counter advance", 64'(lnt_o - a), 64'd5);
    endtask

    task automatic t_fill();
        logic [TSW-1:0] s1, s2;
        send(1'b0, {11'h123, 18'h3FFFF}, 4'd5, 1'b1, 64'h0102030405060708, s1);
        check("R3 first frame top mailbox", 64'(pending_o), 64'h80);
        look(7);
        check("R8 standard identifier word", 64'(rd_id), 64'(std_word(11'h123)));
        check("R9 length code", 64'(rd_dlc), 64'd5);
        check("R9 remote flag", 64'(rd_rtr), 64'd1);
        check("R9 data", rd_data, 64'h0102030405060708);
        check("R7 timestamp", 64'(rd_stamp), 64'(s1));
        send(1'b1, 29'h1ABCDEF5, 4'd8, 1'b0, 64'hCAFE0000BEEF1111, s2);
        check("R3 second frame next mailbox", 64'(pending_o), 64'hC0);
        look(6);
        check("R8 extended identifier word", 64'(rd_id), 64'({3'b100, 29'h1ABCDEF5}));
        check("R7 second timestamp", 64'(rd_stamp), 64'(s2));
        check("R7 stamps ordered", 64'(s2 - s1), 64'd3);
        send_std(11'h010, 64'h33);
        send_std(11'h011, 64'h44);
        check("R3 bank full", 64'(pending_o), 64'hF0);
        check("R2 transmit indices idle", 64'(pending_o[3:0]), 64'h0);
        check("R4 no loss yet", 64'(lost_o), 64'h0);
    endtask

    task automatic t_overflow();
        send_std(11'h055, 64'h55);
        check("R4 overwrite sets lost", 64'(lost_o), 64'h10);
        check("R4 pending kept", 64'(pending_o), 64'hF0);
        look(4);
        check("R4 newest data kept", rd_data, 64'h55);
        look(5);
        check("R4 protected mailbox untouched", rd_data, 64'h33);
        send_std(11'h066, 64'h66);
        check("R4 lost still set", 64'(lost_o), 64'h10);
        look(4);
        check("R4 second overwrite data", rd_data, 64'h66);
    endtask

    task automatic t_irq();
        irq_mask = 8'h20;
        #1;
        check("R10 masked pending raises irq", 64'(rx_irq), 64'd1);
        irq_mask = 8'h0F;
        #1;
        check("R10 mask on idle bits", 64'(rx_irq), 64'd0);
        irq_mask = 8'h00;
    endtask

    task automatic t_clear();
        clear(8'h50);
        check("R6 pending cleared selectively", 64'(pending_o), 64'hA0);
        check("R6 lost cleared with pending", 64'(lost_o), 64'h00);
        send_std(11'h077, 64'h77);
        check("R3 refill highest free", 64'(pending_o), 64'hE0);
        look(6);
        check("R3 refill data", rd_data, 64'h77);
        look(4);
        check("R6 cleared mailbox untouched", rd_data, 64'h66);
    endtask

    task automatic t_back_to_back();
        clear(8'hFF);
        check("R6 clear all", 64'(pending_o), 64'h00);
        @(negedge clk);
        frm_valid = 1'b1; frm_ext = 1'b0; frm_ident = {11'h0A1, 18'd0}; frm_data = 64'hA1;
        @(negedge clk);
        frm_ident = {11'h0B2, 18'd0}; frm_data = 64'hB2;
        @(negedge clk);
        frm_valid = 1'b0;
        @(negedge clk);
        check("R11 both frames stored", 64'(pending_o), 64'hC0);
        look(7);
        check("R11 earlier frame higher", rd_data, 64'hA1);
        look(6);
        check("R11 later frame next", rd_data, 64'hB2);
    endtask

    task automatic t_unprotected_top();
        clear(8'hFF);
        prot_en = 8'h60;
        send_std(11'h0C1, 64'hC1);
        send_std(11'h0C2, 64'hC2);
        check("R4 unprotected top reused", 64'(pending_o), 64'h80);
        check("R4 unprotected top lost", 64'(lost_o), 64'h80);
        look(7);
        check("R4 unprotected top data", rd_data, 64'hC2);
    endtask

    task automatic t_drop();
        clear(8'hFF);
        prot_en = 8'hF0;
        send_std(11'h0D1, 64'hD1);
        send_std(11'h0D2, 64'hD2);
        send_std(11'h0D3, 64'hD3);
        send_std(11'h0D4, 64'hD4);
        send_std(11'h0D5, 64'hD5);
        check("R5 discard keeps pending", 64'(pending_o), 64'hF0);
        check("R5 discard keeps lost", 64'(lost_o), 64'h00);
        look(4);
        check("R5 discard keeps contents", rd_data, 64'hD4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_overflow();
        t_irq();
        t_clear();
        t_back_to_back();
        t_unprotected_top();
        t_drop();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule